// File: doc/BRIEF.md
# Shared Indirect Branch Target Predictor with Context Isolation

This block is a small direct-mapped table of indirect branch targets. Both hardware threads of one core use the same table. Each thread presents its fetch PC every cycle. In the same cycle the thread gets back a hit flag and a predicted target. When an indirect branch resolves, the resolve path writes the real target into the table. The write carries the thread that trained the entry and the privilege level it ran at. A prediction is only a hint. A wrong target is fixed later, when the resolve path writes the correct target.

By default, an entry trained by one thread can steer the other thread. Three controls narrow this.
- A strict speculation mode wipes the whole table whenever either thread moves from user to kernel privilege. While the mode is on, it also hides entries trained by the sibling thread and entries trained at user level from kernel lookups.
- A per-thread mode only hides the sibling thread's entries. It never flushes.
- A barrier pulse drops every entry trained at one chosen privilege level, so that earlier code at that level cannot steer code that runs later.

Top module: `xt_btb`

## Requirements
- R1: After reset, no entry is valid: `t0_hit` and `t1_hit` stay 0 until the first update is written.
- R2: A write on the update port (`up_en`) stores the target at index PC[5:2], with tag PC[15:6], the training thread and the privilege level. From the next cycle, a lookup whose PC has the same index and tag raises hit and drives that target. A lookup with a different tag misses. When hit is 0 the target output is 0.
- R3: With both isolation modes off, an entry trained by one thread is predicted for the other thread.
- R4: With `solo_en` = 1, a thread never hits on an entry trained by the sibling thread, but it still hits on its own entries. A privilege rise does not flush the table in this mode.
- R5: With `strict_en` = 1, a 0-to-1 change of either bit of `th_priv` (1 = kernel) clears every entry. In that cycle neither thread gets a hit, and an update given in the same cycle is dropped.
- R6: With `strict_en` = 1, a thread never hits on a sibling-trained entry. A thread whose `th_priv` bit is 1 never hits on an entry trained with privilege 0.
- R7: A `bar_req` cycle clears every valid entry whose stored privilege equals `bar_priv` and keeps the rest. In that cycle neither thread gets a hit, and an update given in the same cycle is dropped.
- R8: A write to an index that already holds an entry replaces it. The old tag misses from then on.
- R9: A lookup is combinational on the table state, and a write becomes visible on the cycle after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_en | input | 1 | Strict speculation mode |
| solo_en | input | 1 | Per-thread predictor mode |
| th_priv | input | 2 | Current privilege of each thread, 1 = kernel |
| bar_req | input | 1 | Barrier pulse |
| bar_priv | input | 1 | Privilege level that the barrier clears |
| t0_pc | input | 32 | Thread 0 fetch PC |
| t0_hit | output | 1 | Thread 0 prediction valid |
| t0_tgt | output | 32 | Thread 0 predicted target |
| t1_pc | input | 32 | Thread 1 fetch PC |
| t1_hit | output | 1 | Thread 1 prediction valid |
| t1_tgt | output | 32 | Thread 1 predicted target |
| up_en | input | 1 | Resolved-branch write strobe |
| up_tid | input | 1 | Thread that resolved the branch |
| up_priv | input | 1 | Privilege of the resolved branch |
| up_pc | input | 32 | PC of the resolved branch |
| up_tgt | input | 32 | Resolved target |

## Verification
Every piece of table state reaches the ports through the lookup path on the next cycle, because prediction is combinational on the stored entries.

Any of the following would show up as a wrong hit or a wrong target on the very next cycle that either thread fetches at that index:
- a stale valid bit left after a flush or barrier;
- a wrong owner bit or privilege bit;
- an update written when it should have been dropped.

The bench therefore compares both threads' outputs every cycle against a reference table. It mixes isolation modes, privilege changes, barriers and collisions, so that a corrupted entry is seen within a few cycles.

// File: rtl/xt_btb.sv
module xt_btb #(
  parameter int ENTRIES = 16,
  parameter int PC_W    = 32,
  parameter int TAG_W   = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strict_en,
  input  logic            solo_en,
  input  logic [1:0]      th_priv,
  input  logic            bar_req,
  input  logic            bar_priv,
  input  logic [PC_W-1:0] t0_pc,
  output logic            t0_hit,
  output logic [PC_W-1:0] t0_tgt,
  input  logic [PC_W-1:0] t1_pc,
  output logic            t1_hit,
  output logic [PC_W-1:0] t1_tgt,
  input  logic            up_en,
  input  logic            up_tid,
  input  logic            up_priv,
  input  logic [PC_W-1:0] up_pc,
  input  logic [PC_W-1:0] up_tgt
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;

  logic [ENTRIES-1:0] vld_q, own_q, krn_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];
  logic [1:0]         prv_q;

  logic xfer_flush, quiet;
  assign xfer_flush = strict_en & |(th_priv & ~prv_q);
  assign quiet      = xfer_flush | bar_req;

  logic [IDX_W-1:0] up_idx;
  assign up_idx = up_pc[TAG_LO-1:IDX_LO];

  logic [PC_W-1:0]  lk_pc  [2];
  logic [IDX_W-1:0] lk_idx [2];
  logic [1:0]       lk_hit;
  logic [PC_W-1:0]  lk_tgt [2];

  assign lk_pc[0] = t0_pc;
  assign lk_pc[1] = t1_pc;

  for (genvar g = 0; g < 2; g++) begin : g_lk
    logic match, sib_block, usr_block;
    assign lk_idx[g]  = lk_pc[g][TAG_LO-1:IDX_LO];
    assign match      = vld_q[lk_idx[g]] &&
                        (tag_q[lk_idx[g]] == lk_pc[g][TAG_LO+TAG_W-1:TAG_LO]);
    assign sib_block  = (strict_en | solo_en) && (own_q[lk_idx[g]] != 1'(g));
    assign usr_block  = strict_en && th_priv[g] && !krn_q[lk_idx[g]];
    assign lk_hit[g]  = match & ~sib_block & ~usr_block & ~quiet;
    assign lk_tgt[g]  = lk_hit[g] ? tgt_q[lk_idx[g]] : '0;
  end

  assign t0_hit = lk_hit[0];
  assign t1_hit = lk_hit[1];
  assign t0_tgt = lk_tgt[0];
  assign t1_tgt = lk_tgt[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      own_q <= '0;
      krn_q <= '0;
      prv_q <= '0;
    end else begin
      prv_q <= th_priv;
      if (xfer_flush) begin
        vld_q <= '0;
      end else if (bar_req) begin
        for (int i = 0; i < ENTRIES; i++)
          if (krn_q[i] == bar_priv) vld_q[i] <= 1'b0;
      end else if (up_en) begin
        vld_q[up_idx] <= 1'b1;
        own_q[up_idx] <= up_tid;
        krn_q[up_idx] <= up_priv;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (up_en && !quiet) begin
      tag_q[up_idx] <= up_pc[TAG_LO+TAG_W-1:TAG_LO];
      tgt_q[up_idx] <= up_tgt;
    end
  end

  AST_XFER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_flush |=> (vld_q == '0)); // R5
  AST_BAR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bar_req && !xfer_flush) |=> ((vld_q & ($past(bar_priv) ? krn_q : ~krn_q)) == '0)); // R7
  AST_UPD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !quiet) |=> vld_q[$past(up_idx)]); // R2
  AST_T0_NO_SIB: assert property (@(posedge clk) disable iff (!rst_n)
    ((strict_en || solo_en) && t0_hit) |-> !own_q[lk_idx[0]]); // R4
  AST_T1_NO_SIB: assert property (@(posedge clk) disable iff (!rst_n)
    ((strict_en || solo_en) && t1_hit) |-> own_q[lk_idx[1]]); // R6
  AST_KRN_NO_USR: assert property (@(posedge clk) disable iff (!rst_n)
    (strict_en && th_priv[0] && t0_hit) |-> krn_q[lk_idx[0]]); // R6
  AST_QUIET_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bar_req) |-> (!t0_hit && !t1_hit)); // R7
endmodule

// File: tb/xt_btb_tb.sv
module xt_btb_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strict_en = 1'b0, solo_en = 1'b0;
  logic [1:0]  th_priv = 2'b00;
  logic        bar_req = 1'b0, bar_priv = 1'b0;
  logic [31:0] t0_pc = '0, t1_pc = '0;
  logic        t0_hit, t1_hit;
  logic [31:0] t0_tgt, t1_tgt;
  logic        up_en = 1'b0, up_tid = 1'b0, up_priv = 1'b0;
  logic [31:0] up_pc = '0, up_tgt = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  bit        mv [16];
  bit        mown [16];
  bit        mkrn [16];
  bit [9:0]  mtag [16];
  bit [31:0] mtgt [16];
  bit [1:0]  mprv = 2'b00;

  always #10 clk = ~clk;

  xt_btb u_dut (
    .clk(clk), .rst_n(rst_n), .strict_en(strict_en), .solo_en(solo_en),
    .th_priv(th_priv), .bar_req(bar_req), .bar_priv(bar_priv),
    .t0_pc(t0_pc), .t0_hit(t0_hit), .t0_tgt(t0_tgt),
    .t1_pc(t1_pc), .t1_hit(t1_hit), .t1_tgt(t1_tgt),
    .up_en(up_en), .up_tid(up_tid), .up_priv(up_priv),
    .up_pc(up_pc), .up_tgt(up_tgt));

  function automatic logic [31:0] mk_pc(input logic [9:0] tg, input logic [3:0] ix);
    logic [31:0] r;
    r = '0;
    r[15:6] = tg;
    r[5:2]  = ix;
    return r;
  endfunction

  function automatic bit m_quiet();
    return (strict_en && ((th_priv & ~mprv) != 2'b00)) || bar_req;
  endfunction

  function automatic bit m_hit(input int g, input logic [31:0] pc);
    int i;
    i = int'(pc[5:2]);
    if (!rst_n || m_quiet() || !mv[i]) return 0;
    if (mtag[i] != pc[15:6]) return 0;
    if ((strict_en || solo_en) && (mown[i] != g[0])) return 0;
    if (strict_en && th_priv[g] && !mkrn[i]) return 0;
    return 1;
  endfunction

  task automatic cmp1(input string req, input int g, input logic [31:0] pc,
                      input logic hit, input logic [31:0] tgt);
    bit eh;
    logic [31:0] et;
    eh = m_hit(g, pc);
    et = eh ? mtgt[pc[5:2]] : 32'h0;
    n_cmp++;
    if (hit !== eh || tgt !== et) begin
      n_bad++;
      $display("FAIL %s thread%0d pc=%h: got hit=%b tgt=%h, expected hit=%b tgt=%h",
               req, g, pc, hit, tgt, eh, et);
    end
  endtask

  task automatic m_clock();
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mv[i] = 0;
      mprv = 2'b00;
    end else begin
      if (strict_en && ((th_priv & ~mprv) != 2'b00)) begin
        for (int i = 0; i < 16; i++) mv[i] = 0;
      end else if (bar_req) begin
        for (int i = 0; i < 16; i++) if (mkrn[i] == bar_priv) mv[i] = 0;
      end else if (up_en) begin
        mv[up_pc[5:2]]   = 1;
        mown[up_pc[5:2]] = up_tid;
        mkrn[up_pc[5:2]] = up_priv;
        mtag[up_pc[5:2]] = up_pc[15:6];
        mtgt[up_pc[5:2]] = up_tgt;
      end
      mprv = th_priv;
    end
  endtask

  // inputs are set just after a falling edge; tick checks, then advances one cycle
  task automatic tick(input string req);
    #2;
    cmp1(req, 0, t0_pc, t0_hit, t0_tgt);
    cmp1(req, 1, t1_pc, t1_hit, t1_tgt);
    @(posedge clk);
    m_clock();
    @(negedge clk);
    up_en = 0;
    bar_req = 0;
  endtask

  task automatic upd(input bit tid, input bit pv, input logic [31:0] pc, input logic [31:0] tg);
    up_en = 1; up_tid = tid; up_priv = pv; up_pc = pc; up_tgt = tg;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    report();
  end

  initial begin
    logic [31:0] pa, pb, pc2;
    void'($urandom(32'd1234));
    @(negedge clk);
    t0_pc = mk_pc(10'h3, 4'h5);
    tick("R1");
    tick("R1");
    rst_n = 1;
    tick("R1");

    // R2 / R3 / R9
    pa = mk_pc(10'h11, 4'h5);
    pb = mk_pc(10'h12, 4'h5);
    upd(0, 0, pa, 32'hA000_0040);
    t0_pc = pa; t1_pc = pa;
    tick("R9");
    t1_pc = pb;
    tick("R2");
    t1_pc = pa;
    tick("R3");

    // R8 overwrite
    upd(1, 0, pb, 32'hB000_0080);
    tick("R8");
    t0_pc = pa; t1_pc = pb;
    tick("R8");

    // R4 single-thread mode
    pc2 = mk_pc(10'h21, 4'h9);
    upd(0, 0, pc2, 32'hC000_0100);
    tick("R4");
    solo_en = 1;
    t0_pc = pc2; t1_pc = pc2;
    tick("R4");
    th_priv = 2'b01;
    tick("R4");
    tick("R4");
    th_priv = 2'b00; solo_en = 0;
    tick("R4");

    // R5 strict mode flush on privilege rise
    strict_en = 1;
    upd(1, 0, mk_pc(10'h22, 4'h9), 32'hD000_0000);
    t1_pc = mk_pc(10'h22, 4'h9);
    tick("R5");
    tick("R5");
    th_priv = 2'b10;
    upd(1, 1, mk_pc(10'h23, 4'hA), 32'hD000_0400);
    t0_pc = mk_pc(10'h23, 4'hA);
    tick("R5");
    tick("R5");

    // R6 sibling and user-entry blocking
    upd(1, 0, mk_pc(10'h30, 4'h1), 32'hE000_0000);
    tick("R6");
    upd(1, 1, mk_pc(10'h31, 4'h2), 32'hE000_0010);
    t1_pc = mk_pc(10'h30, 4'h1);
    t0_pc = mk_pc(10'h31, 4'h2);
    tick("R6");
    t1_pc = mk_pc(10'h31, 4'h2);
    tick("R6");
    strict_en = 0; th_priv = 2'b00;
    tick("R6");

    // R7 barrier
    upd(0, 0, mk_pc(10'h40, 4'h3), 32'hF000_0000);
    tick("R7");
    upd(1, 1, mk_pc(10'h41, 4'h4), 32'hF000_0100);
    tick("R7");
    t0_pc = mk_pc(10'h40, 4'h3); t1_pc = mk_pc(10'h41, 4'h4);
    bar_req = 1; bar_priv = 0;
    upd(0, 0, mk_pc(10'h42, 4'h6), 32'hF000_0200);
    tick("R7");
    tick("R7");
    t0_pc = mk_pc(10'h42, 4'h6);
    tick("R7");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 49) == 0) strict_en = ~strict_en;
      if ($urandom_range(0, 49) == 0) solo_en = ~solo_en;
      if ($urandom_range(0, 15) == 0) th_priv[$urandom_range(0, 1)] ^= 1'b1;
      if ($urandom_range(0, 39) == 0) begin bar_req = 1; bar_priv = 1'($urandom); end
      if ($urandom_range(0, 2) == 0)
        upd(1'($urandom), 1'($urandom), mk_pc(10'($urandom_range(0, 3)), 4'($urandom)), $urandom);
      t0_pc = mk_pc(10'($urandom_range(0, 3)), 4'($urandom));
      t1_pc = mk_pc(10'($urandom_range(0, 3)), 4'($urandom));
      tick("R2");
    end
    report();
  end
endmodule